// File: doc/BRIEF.md
# Fixed-Priority Central Bus Arbiter

This block sits at the centre of a shared bus that several masters may drive. Every master has a dedicated request input and a dedicated grant output. A master raises its request when it wants the bus. It must not drive the bus until its grant bit is high. It keeps its request high for as long as it needs the bus, and it lowers the request when it has finished.

Among the requesters, the one with the lowest index always wins a free bus. Once a master holds the grant, it keeps it until it releases its request, even if a master of higher priority starts asking in the meantime. While an owner is in its tenure, the arbiter keeps working out which of the other requesters would come next. This lets the grant move to that master at the same clock edge where the owner lets go, so no idle cycle falls between two tenures.

A mode input turns on bus parking. With parking on, the last owner keeps its grant while nobody is requesting, so it can start another transaction at once. Outputs are the one-hot grant vector and a busy flag. There is no data path and no handshake at the block's edge: requests and grants are plain level signals.

Top module: `bus_prio_arbiter`

## Requirements
- R1: At most one bit of `gnt` is high in any cycle, and `gnt` changes only at a rising edge of `clk`.
- R2: When the bus is free (no owner, or a parked owner), the next edge grants the requester with the lowest index, where bit 0 of `req` has the highest priority, and grants nobody who was not requesting.
- R3: While the granted master keeps its request high, its grant is held, whatever any other master requests.
- R4: At the edge where the owner's request is sampled low and another master is requesting, the grant moves straight to the lowest-index other requester, with no cycle of all-low grants in between.
- R5: With `park_en` low, an edge that samples `req` all zero leaves `gnt` all zero.
- R6: With `park_en` high, an edge that samples `req` all zero while a grant is held keeps that same grant.
- R7: A parked bus is arbitrated like a free bus: the parked owner, or any other master, that requests is granted by priority at the next edge.
- R8: `bus_busy` is high exactly when the current grant was given to, or kept by, a master that was requesting at the last edge. It is low when the bus is idle or parked.
- R9: An active-low `rst_n` clears all grants and `bus_busy` at once, whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| park_en | input | 1 | 1: the last owner keeps the grant while no one requests |
| req | input | N_MASTERS | Request per master; bit 0 has the highest priority |
| gnt | output | N_MASTERS | One-hot grant per master, registered |
| bus_busy | output | 1 | A requesting master currently owns the bus |

## Verification
The bench raises a higher-priority request during a tenure. A design without sticky grants would move the grant away too early. It drops the owner's request while others are waiting. A design that did not compute the next winner ahead would show a cycle with no grant, or would pick the wrong next master. Parking is checked both ways: the grant must be kept, with `bus_busy` low, and then lost again once `park_en` is lowered. A parked bus is also handed to a new requester and reclaimed by its old owner, which catches a design that sits parked forever or ignores the parked owner. A reset in the middle of a tenure must clear the grant at once, without waiting for a clock edge.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_OWNED  = 2'd1,
    ST_PARKED = 2'd2
  } arb_state_e;
endpackage

// File: rtl/arb_lowest_pick.sv
// Lowest-index selector: a one-hot pick of the first set bit.
module arb_lowest_pick #(
  parameter int N = 4
) (
  input  logic [N-1:0] vec,
  output logic [N-1:0] pick,
  output logic         any
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;
  for (genvar i = 0; i < N; i++) begin : g_chain
    assign pick[i]   = vec[i] & ~seen[i];
    assign seen[i+1] = seen[i] | vec[i];
  end
  assign any = seen[N];
endmodule

// File: rtl/bus_prio_arbiter.sv
module bus_prio_arbiter #(
  parameter int N_MASTERS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 park_en,
  input  logic [N_MASTERS-1:0] req,
  output logic [N_MASTERS-1:0] gnt,
  output logic                 bus_busy
);
  import arb_pkg::*;

  arb_state_e           state_q, state_d;
  logic [N_MASTERS-1:0] gnt_q, gnt_d;
  logic [N_MASTERS-1:0] free_pick, next_pick, others;
  logic                 free_any, next_any, holding;

  // winner when the bus is free
  arb_lowest_pick #(.N(N_MASTERS)) i_free_pick (
    .vec(req), .pick(free_pick), .any(free_any)
  );

  // next winner, resolved during the current tenure
  assign others = req & ~gnt_q;
  arb_lowest_pick #(.N(N_MASTERS)) i_next_pick (
    .vec(others), .pick(next_pick), .any(next_any)
  );

  assign holding = |(gnt_q & req);

  always_comb begin
    state_d = state_q;
    gnt_d   = gnt_q;
    case (state_q)
      ST_OWNED: begin
        if (holding) begin
          state_d = ST_OWNED;
        end else if (next_any) begin
          gnt_d   = next_pick;
          state_d = ST_OWNED;
        end else if (park_en) begin
          state_d = ST_PARKED;
        end else begin
          gnt_d   = '0;
          state_d = ST_IDLE;
        end
      end
      default: begin
        if (free_any) begin
          gnt_d   = free_pick;
          state_d = ST_OWNED;
        end else if (park_en && state_q == ST_PARKED) begin
          state_d = ST_PARKED;
        end else begin
          gnt_d   = '0;
          state_d = ST_IDLE;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      gnt_q   <= '0;
    end else begin
      state_q <= state_d;
      gnt_q   <= gnt_d;
    end
  end

  assign gnt      = gnt_q;
  assign bus_busy = (state_q == ST_OWNED);
endmodule

// File: rtl/bus_prio_arbiter_chk.sv
module bus_prio_arbiter_chk #(
  parameter int N_MASTERS = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 park_en,
  input logic [N_MASTERS-1:0] req,
  input logic [N_MASTERS-1:0] gnt,
  input logic                 bus_busy
);
  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt)); // R1

  AST_NEW_GNT_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
    ((|req) && !(|(gnt & req))) |=> ((gnt != '0) && (($past(req) & gnt) != '0) && (($past(req) & (gnt - 1'b1)) == '0))); // R2

  AST_HOLD_TENURE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_busy && (|(gnt & req))) |=> $stable(gnt)); // R3

  AST_NO_IDLE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (|req) |=> (bus_busy && (gnt != '0))); // R4

  AST_NOPARK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (!park_en && (req == '0)) |=> (gnt == '0)); // R5

  AST_PARK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (park_en && (req == '0) && (gnt != '0)) |=> ($stable(gnt) && !bus_busy)); // R6

  AST_BUSY_HAS_GNT: assert property (@(posedge clk) disable iff (!rst_n)
    bus_busy |-> (gnt != '0)); // R8
endmodule

bind bus_prio_arbiter bus_prio_arbiter_chk #(.N_MASTERS(N_MASTERS)) i_chk (
  .clk(clk), .rst_n(rst_n), .park_en(park_en),
  .req(req), .gnt(gnt), .bus_busy(bus_busy)
);

// File: tb/test_bus_prio_arbiter.sv
module test_bus_prio_arbiter;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         park_en = 1'b0;
  logic [N-1:0] req = '0;
  logic [N-1:0] gnt;
  logic         bus_busy;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  bus_prio_arbiter #(.N_MASTERS(N)) i_bus_prio_arbiter (
    .clk(clk), .rst_n(rst_n), .park_en(park_en),
    .req(req), .gnt(gnt), .bus_busy(bus_busy)
  );

  // {park_en, req[3:0], expected gnt[3:0], expected busy}
  localparam int NV = 17;
  localparam logic [9:0] VEC [NV] = '{
    {1'b0, 4'b0000, 4'b0000, 1'b0}, // R5 idle
    {1'b0, 4'b1010, 4'b0010, 1'b1}, // R2 lowest index wins
    {1'b0, 4'b1011, 4'b0010, 1'b1}, // R3 hold against master 0
    {1'b0, 4'b1001, 4'b0001, 1'b1}, // R4 handoff, no gap
    {1'b0, 4'b1000, 4'b1000, 1'b1}, // R4 handoff
    {1'b0, 4'b0000, 4'b0000, 1'b0}, // R5 release clears
    {1'b1, 4'b0100, 4'b0100, 1'b1}, // R2
    {1'b1, 4'b0000, 4'b0100, 1'b0}, // R6 parked
    {1'b1, 4'b0100, 4'b0100, 1'b1}, // R7 owner reclaims
    {1'b1, 4'b0000, 4'b0100, 1'b0}, // R6
    {1'b1, 4'b1000, 4'b1000, 1'b1}, // R7 other takes parked bus
    {1'b1, 4'b0000, 4'b1000, 1'b0}, // R6
    {1'b0, 4'b0000, 4'b0000, 1'b0}, // R5 park off drops grant
    {1'b0, 4'b1111, 4'b0001, 1'b1}, // R2 all request
    {1'b0, 4'b1110, 4'b0010, 1'b1}, // R4
    {1'b0, 4'b1100, 4'b0100, 1'b1}, // R4
    {1'b0, 4'b0000, 4'b0000, 1'b0}  // R8 busy low when idle
  };

  task automatic check(input string tag, input logic [N-1:0] eg, input logic eb);
    n_tests++;
    if (gnt !== eg || bus_busy !== eb) begin
      n_fail++;
      $display("FAIL %s: gnt=%b busy=%b expected gnt=%b busy=%b", tag, gnt, bus_busy, eg, eb);
    end
  endtask

  task automatic step(input logic p, input logic [N-1:0] r);
    @(negedge clk);
    park_en = p;
    req     = r;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #50;
    fork
      begin : watchdog
        #400000;
        n_fail++;
        $display("FAIL watchdog: run hung, actual=timeout expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
      end
    join_none
  end

  initial begin
    req = 4'b0101;
    repeat (3) @(posedge clk);
    #1;
    check("R9 reset clears grants", 4'b0000, 1'b0);
    @(negedge clk);
    req   = '0;
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][9], VEC[i][8:5]);
      check($sformatf("R%0s vector %0d", "2-8", i), VEC[i][4:1], VEC[i][0]);
    end

    // R3: owner held over many cycles while all others ask
    step(1'b0, 4'b0100);
    for (int k = 0; k < 5; k++) begin
      step(1'b0, 4'b1111);
      check("R3 long tenure", 4'b0100, 1'b1);
    end
    // R4: release with two waiting, lower index next
    step(1'b0, 4'b1011);
    check("R4 handoff to lowest other", 4'b0001, 1'b1);

    // R9: asynchronous reset in mid-tenure
    @(negedge clk);
    #0.5;
    rst_n = 1'b0;
    #0.5;
    check("R9 async reset mid-tenure", 4'b0000, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    req   = '0;
    step(1'b1, 4'b0000);
    check("R9 stays idle after reset", 4'b0000, 1'b0);

    // R1: one-hot seen across a burst of patterns
    for (int k = 0; k < 16; k++) begin
      step(1'b0, N'(k));
      n_tests++;
      if (!$onehot0(gnt)) begin
        n_fail++;
        $display("FAIL R1 onehot: gnt=%b expected at most one bit", gnt);
      end
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule